// File: doc/BRIEF.md
# Synchronization Status Message Frame Receiver

This block watches one port's received Ethernet byte stream. The stream marks the first and last byte of each frame, carries a valid qualifier, and has an error flag that can be raised on any beat. The block picks out synchronization status message frames and checks their fixed header fields. It then reads the first TLV of the data area. From that TLV it keeps the clock quality code and the clock source identifier.

A once-per-second tick drives a silence timer. The timer restarts on every frame the block accepts. When no accepted frame has arrived for a set number of ticks, the block raises a timeout flag. While that flag is high, the reported quality is forced to the do-not-use code 4'hF, so clock selection logic downstream stops using the port. The last source identifier is still shown.

Top module: `ssm_rx`

## Requirements
- R1: After reset, `ql_out` is 4'hF, `src_id_out` is 4'h0 and `timed_out` is 1.
- R2: Byte positions count from 0 at the start-of-frame byte, and only beats with `in_valid` high count. A frame is accepted when all of the following hold:
  - bytes 12..13 are 0x88, 0x09;
  - bytes 14..15 are 0x00, 0x01;
  - bytes 16..18 equal parameter `OUI`, most significant byte first;
  - byte 19 has bits 7:4 equal to 1 and bit 3 equal to 0;
  - bytes 20, 21, 22 are 0x01, 0x00, 0x04;
  - the frame is at least 84 bytes long.

  On the clock edge that takes the end-of-frame byte of an accepted frame, `ql_out` takes bits 3:0 of byte 23 and `src_id_out` takes bits 7:4 of byte 23, and `timed_out` clears. Idle cycles inside a frame have no effect.
- R3: A frame whose bytes 12..13 are not 0x88, 0x09 leaves every output unchanged.
- R4: A frame with a wrong value in bytes 14..15 or in the organization identifier bytes 16..18 leaves every output unchanged.
- R5: A frame whose byte 19 has a version other than 1 (bits 7:4), or has the event bit (bit 3) set, leaves every output unchanged.
- R6: A frame whose first TLV type (byte 20) is not 0x01, or whose TLV length (bytes 21..22) is not 0x0004, leaves every output unchanged.
- R7: A frame of 83 bytes or fewer (less than 64 bytes from byte 20 onward) is dropped. A frame of exactly 84 bytes is accepted.
- R8: A frame with `in_err` high on any of its beats is dropped.
- R9: After `TIMEOUT_S` tick cycles with no accepted frame, `timed_out` is 1 and `ql_out` reads 4'hF. After `TIMEOUT_S`-1 such ticks, neither has changed. `src_id_out` keeps its value.
- R10: An accepted frame restarts the silence count from zero, including when a tick arrives on its end-of-frame beat.
- R11: A start-of-frame byte arriving inside an unfinished frame abandons that frame and starts parsing anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Received byte |
| in_err | input | 1 | Frame error flag for this beat |
| tick_1hz | input | 1 | One-cycle pulse per second |
| ql_out | output | 4 | Reported quality code, 4'hF when timed out |
| src_id_out | output | 4 | Last accepted source identifier |
| timed_out | output | 1 | Silence timeout reached |

## Verification
The bench builds the block with `TIMEOUT_S` set to 3 and keeps the default `OUI` and 84-byte minimum frame. A short timeout lets the bench reach both sides of the expiry boundary (two ticks versus three) in a few cycles. It also lets the bench show that the count restarts after a frame that ends in the same cycle as a tick. The 84-byte default keeps the 83-byte and 84-byte boundary frames exactly as the requirements state them.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  localparam logic [3:0] QL_DNU    = 4'hF;
  localparam int         VAL_POS   = 23;
  localparam int         DATA_POS  = 20;

  // Checks one byte against the fixed header and TLV fields at its position.
  function automatic logic field_ok(input int pos, input logic [7:0] d,
                                    input logic [23:0] oui);
    logic r;
    case (pos)
      12:      r = (d == 8'h88);
      13:      r = (d == 8'h09);
      14:      r = (d == 8'h00);
      15:      r = (d == 8'h01);
      16:      r = (d == oui[23:16]);
      17:      r = (d == oui[15:8]);
      18:      r = (d == oui[7:0]);
      19:      r = (d[7:4] == 4'd1) && !d[3];
      20:      r = (d == 8'h01);
      21:      r = (d == 8'h00);
      22:      r = (d == 8'h04);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ssm_frame_track.sv
module ssm_frame_track #(
  parameter int MIN_FRAME = 84,
  localparam int PW = $clog2(MIN_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          beat,
  output logic          first,
  output logic [PW-1:0] cur_pos,
  output logic          long_enough
);

  logic          active_q, active_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign first       = in_valid && in_sop;
  assign beat        = in_valid && (in_sop || active_q);
  assign cur_pos     = in_sop ? '0 : cnt_q;
  assign long_enough = (cur_pos >= PW'(MIN_FRAME - 1));
  assign cnt_en      = beat;

  always_comb begin
    active_d = active_q;
    if (in_valid) active_d = (in_sop || active_q) && !in_eop;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cur_pos != PW'(MIN_FRAME)) cnt_d = cur_pos + PW'(1);
    else                           cnt_d = cur_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ssm_field_check.sv
module ssm_field_check #(
  parameter logic [23:0] OUI = 24'h0019A7,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          first,
  input  logic [PW-1:0] cur_pos,
  input  logic [7:0]    in_data,
  input  logic          in_err,
  output logic          ok_now,
  output logic [7:0]    value
);
  import ssm_pkg::*;

  logic       ok_q;
  logic       grab_en;
  logic       match;

  assign match   = field_ok(int'(cur_pos), in_data, OUI);
  assign ok_now  = (first ? 1'b1 : ok_q) && match && !in_err;
  assign grab_en = beat && (cur_pos == PW'(VAL_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      value <= '0;
    end else begin
      if (beat)    ok_q  <= ok_now;
      if (grab_en) value <= in_data;
    end
  end

endmodule

// File: rtl/ssm_silence_timer.sv
module ssm_silence_timer #(
  parameter int TIMEOUT_S = 5,
  localparam int CW = $clog2(TIMEOUT_S + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          tick,
  output logic          expired,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (count == CW'(TIMEOUT_S));
  assign cnt_en  = accept || (tick && !expired);

  always_comb begin
    if (accept) cnt_d = '0;
    else        cnt_d = count + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= CW'(TIMEOUT_S);
    else if (cnt_en) count <= cnt_d;
  end

endmodule

// File: rtl/ssm_rx.sv
module ssm_rx #(
  parameter int          TIMEOUT_S = 5,
  parameter int          MIN_FRAME = 84,
  parameter logic [23:0] OUI       = 24'h0019A7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  input  logic       in_err,
  input  logic       tick_1hz,
  output logic [3:0] ql_out,
  output logic [3:0] src_id_out,
  output logic       timed_out
);
  import ssm_pkg::*;

  localparam int PW = $clog2(MIN_FRAME + 1);
  localparam int CW = $clog2(TIMEOUT_S + 1);

  logic          beat, first, long_enough, ok_now, accept;
  logic [PW-1:0] cur_pos;
  logic [7:0]    value;
  logic [CW-1:0] sil_count;
  logic [3:0]    ql_q;
  logic          err_end, short_end;

  ssm_frame_track #(.MIN_FRAME(MIN_FRAME)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .beat(beat), .first(first), .cur_pos(cur_pos),
    .long_enough(long_enough)
  );

  ssm_field_check #(.OUI(OUI), .PW(PW)) u_fields (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .cur_pos(cur_pos),
    .in_data(in_data), .in_err(in_err), .ok_now(ok_now), .value(value)
  );

  assign accept    = beat && in_eop && ok_now && long_enough;
  assign err_end   = beat && in_eop && in_err;
  assign short_end = beat && in_eop && !long_enough;

  ssm_silence_timer #(.TIMEOUT_S(TIMEOUT_S)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .tick(tick_1hz),
    .expired(timed_out), .count(sil_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ql_q       <= QL_DNU;
      src_id_out <= 4'h0;
    end else if (accept) begin
      ql_q       <= value[3:0];
      src_id_out <= value[7:4];
    end
  end

  assign ql_out = timed_out ? QL_DNU : ql_q;

endmodule

// File: rtl/ssm_rx_chk.sv
module ssm_rx_chk #(
  parameter int TIMEOUT_S = 5,
  localparam int CW = $clog2(TIMEOUT_S + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic [7:0]    value,
  input logic          tick,
  input logic          err_end,
  input logic          short_end,
  input logic [CW-1:0] count,
  input logic [3:0]    ql_out,
  input logic [3:0]    src_id_out,
  input logic          timed_out
);

  assert_latch_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ql_out == $past(value[3:0]) && src_id_out == $past(value[7:4])));

  assert_short_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> $stable(src_id_out));

  assert_err_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_end |=> $stable(src_id_out));

  assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !accept && count == CW'(TIMEOUT_S - 1)) |=> timed_out);

  assert_expiry_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !accept) |=> (timed_out && ql_out == 4'hF));

  assert_accept_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !timed_out);

endmodule

bind ssm_rx ssm_rx_chk #(.TIMEOUT_S(TIMEOUT_S)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .value(value), .tick(tick_1hz),
  .err_end(err_end), .short_end(short_end), .count(sil_count),
  .ql_out(ql_out), .src_id_out(src_id_out), .timed_out(timed_out)
);

// File: tb/test_ssm_rx.sv
module test_ssm_rx;
  localparam int T = 3;

  logic       clk, rst_n;
  logic       in_valid, in_sop, in_eop, in_err, tick_1hz;
  logic [7:0] in_data;
  logic [3:0] ql_out, src_id_out;
  logic       timed_out;

  ssm_rx #(.TIMEOUT_S(T)) i_ssm_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .in_err(in_err), .tick_1hz(tick_1hz),
    .ql_out(ql_out), .src_id_out(src_id_out), .timed_out(timed_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [3:0] ql;
    logic [3:0] src;
    logic       to;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0, errors = 0;
  bit         done = 0;
  logic [7:0] fb [0:127];
  int         flen;
  logic [3:0] m_ql, m_src;
  int         m_cnt;

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ql_out !== e.ql || src_id_out !== e.src || timed_out !== e.to) begin
        errors++;
        $display("FAIL %s: got ql=%h src=%h to=%b, expected ql=%h src=%h to=%b",
                 e.tag, ql_out, src_id_out, timed_out, e.ql, e.src, e.to);
      end
    end
  end

  task automatic expect_state(input string tag);
    exp_t e;
    e.to  = (m_cnt >= T);
    e.ql  = e.to ? 4'hF : m_ql;
    e.src = m_src;
    e.tag = tag;
    sb.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic mk_frame(input logic [7:0] val, input int len);
    for (int i = 0; i < 128; i++) fb[i] = 8'(i * 3 + 8'h5A);
    fb[12] = 8'h88; fb[13] = 8'h09; fb[14] = 8'h00; fb[15] = 8'h01;
    fb[16] = 8'h00; fb[17] = 8'h19; fb[18] = 8'hA7; fb[19] = 8'h12;
    fb[20] = 8'h01; fb[21] = 8'h00; fb[22] = 8'h04; fb[23] = val;
    flen = len;
  endtask

  task automatic idle();
    in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0; tick_1hz = 0;
    in_data = 8'h00;
  endtask

  task automatic play(input bit gaps, input int err_at, input bit tick_eop,
                      input bit no_eop);
    for (int i = 0; i < flen; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk); idle();
      end
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == flen - 1) && !no_eop;
      in_data = fb[i]; in_err = (i == err_at);
      tick_1hz = tick_eop && (i == flen - 1);
    end
    @(negedge clk); idle();
  endtask

  task automatic good_seen();
    m_ql = fb[23][3:0]; m_src = fb[23][7:4]; m_cnt = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1;
      @(negedge clk); tick_1hz = 0;
      m_cnt++;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; m_ql = 4'hF; m_src = 4'h0; m_cnt = T;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_state("R1 reset state");

    mk_frame(8'h52, 84); play(1, -1, 0, 0); good_seen();
    expect_state("R2 valid frame with gaps");

    mk_frame(8'h38, 90); fb[13] = 8'h08; play(0, -1, 0, 0);
    expect_state("R3 wrong ethertype");

    mk_frame(8'h38, 90); fb[15] = 8'h02; play(0, -1, 0, 0);
    expect_state("R4 wrong subtype");
    mk_frame(8'h38, 90); fb[17] = 8'h18; play(0, -1, 0, 0);
    expect_state("R4 wrong organization id");

    mk_frame(8'h38, 90); fb[19] = 8'h20; play(0, -1, 0, 0);
    expect_state("R5 wrong version");
    mk_frame(8'h38, 90); fb[19] = 8'h18; play(0, -1, 0, 0);
    expect_state("R5 event bit set");

    mk_frame(8'h38, 90); fb[20] = 8'h02; play(0, -1, 0, 0);
    expect_state("R6 wrong tlv type");
    mk_frame(8'h38, 90); fb[22] = 8'h05; play(0, -1, 0, 0);
    expect_state("R6 wrong tlv length");

    mk_frame(8'h38, 83); play(0, -1, 0, 0);
    expect_state("R7 83-byte frame dropped");
    mk_frame(8'h7B, 84); play(1, -1, 0, 0); good_seen();
    expect_state("R7 84-byte frame accepted");

    mk_frame(8'h94, 90); play(0, 40, 0, 0);
    expect_state("R8 error mid frame");
    mk_frame(8'h94, 90); play(0, 89, 0, 0);
    expect_state("R8 error on last beat");

    tick(T - 1);
    expect_state("R9 one tick short of timeout");
    tick(1);
    expect_state("R9 timeout reached");

    mk_frame(8'h61, 84); play(0, -1, 0, 0); good_seen();
    expect_state("R10 frame clears timeout");
    tick(T - 1);
    mk_frame(8'h62, 84); play(0, -1, 1, 0); good_seen();
    tick(T - 1);
    expect_state("R10 tick on eop restarts count");
    tick(1);
    expect_state("R10 expiry after restart");

    mk_frame(8'hAA, 40); fb[13] = 8'h00; play(0, -1, 0, 1);
    mk_frame(8'hC8, 84); play(0, -1, 0, 0); good_seen();
    expect_state("R11 sop restarts parsing");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule